// File: doc/BRIEF.md
# Serial test command receiver

This block is the receiving end of a synchronous, clocked test link used on the production line to program and exercise a sensor conditioning chip. The host drives the link clock, a framing line, and a serial data pin. The link is live only while the test enable and two chip-select inputs are all high, so many devices can share the same wires. Once the framing line has been held low long enough and then released, the block assembles 32-bit command words one bit per rising clock edge. The host changes the data pin on the falling edge.

Each finished word is split into four fields: a 16-bit coefficient value, a 7-bit EEPROM bit address, a 3-bit register index and a 4-bit opcode. The block then raises exactly one single-cycle command strobe. A coefficient write, an EEPROM bit set, an EEPROM erase and a no-operation each have their own strobe. A conversion start carries two qualifiers: whether coefficients are reloaded from EEPROM and whether trace output is enabled. A conversion start also parks the receiver until the next initialization. While the framing line is held low on a live link, a clear request for the coefficient registers is raised.

Top module: `test_cmd_rx`

## Requirements
- R1: While the link is not live (any of test_en, cs_a, cs_b low), every input is ignored. All internal state is frozen, no strobe is raised and coef_clr is low. A word interrupted by deselection resumes where it stopped.
- R2: A word begins only when init_line is sampled high at a rising edge that follows at least INIT_LOW (16) consecutive live rising edges with init_line low. The data bit sampled on that edge is bit 0. Fifteen low edges are not enough.
- R3: Bits arrive first-to-last as word bit 0 to bit 31. The fields are: bits 15:0 coefficient value, bits 22:16 EEPROM bit address (0x00 to 0x7F), bits 25:23 register index, bits 29:26 opcode. Bits 31:30 are unused and have no effect.
- R4: Opcode 0x1 raises cmd_wr, 0x2 raises cmd_set, 0x4 raises cmd_erase and 0x0 raises cmd_nop. At most one strobe is high in any cycle.
- R5: The reserved opcodes 0x3, 0x5, 0x6, 0x7, 0x9, 0xB, 0xD and 0xF raise cmd_nop and nothing else.
- R6: Opcodes 0x8, 0xA, 0xC and 0xE raise cmd_start. start_reload is high for 0xA and 0xE. start_trace is high for 0x8 and 0xA.
- R7: After a start word, no further strobe is raised until a new initialization (R2) has taken place.
- R8: coef_clr is high in the cycle after each live rising edge at which init_line is sampled low, and low otherwise.
- R9: A strobe is high for the single cycle after the rising edge that samples bit 31. The field outputs change only together with a strobe and are otherwise held.
- R10: Words follow one another back to back with no gap and no new initialization, until a start word arrives.
- R11: Sampling init_line low in the middle of a word discards that word. A new initialization is then required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock driven by the host |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| test_en | input | 1 | Test mode enable |
| cs_a | input | 1 | First chip select, active high |
| cs_b | input | 1 | Second chip select, active high |
| init_line | input | 1 | Framing line: held low to initialize, high to shift |
| sdata | input | 1 | Serial command data |
| cmd_wr | output | 1 | Coefficient register write strobe |
| cmd_set | output | 1 | EEPROM single-bit set strobe |
| cmd_erase | output | 1 | EEPROM erase-all strobe |
| cmd_nop | output | 1 | No-operation strobe (also for reserved opcodes) |
| cmd_start | output | 1 | Conversion start strobe |
| start_reload | output | 1 | Start reloads coefficients from EEPROM |
| start_trace | output | 1 | Start enables trace output |
| fld_data | output | 16 | Coefficient value field |
| fld_eaddr | output | 7 | EEPROM bit address field |
| fld_raddr | output | 3 | Coefficient register index |
| coef_clr | output | 1 | Clear request for the coefficient registers |

## Verification
The checker watches several properties on every cycle: the strobes are mutually exclusive single-cycle pulses, the fields hold still between strobes, a parked receiver stays silent, and both the clear request and the strobes follow the live-link condition. The bench shows the behaviours that depend on a sequence of inputs. These are the exact bit-to-field mapping, the 15-versus-16 boundary of the initialization count, resuming a word across a deselection, discarding a word on an early framing drop, and the four start variants each followed by a silent word.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int WORD_W  = 32;
  localparam int DATA_W  = 16;
  localparam int EADDR_W = 7;
  localparam int RADDR_W = 3;
  localparam int OP_W    = 4;
  localparam int EA_LSB  = DATA_W;
  localparam int RA_LSB  = EA_LSB + EADDR_W;
  localparam int OP_LSB  = RA_LSB + RADDR_W;
  localparam int USED_W  = OP_LSB + OP_W;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HALT} rx_state_t;
  typedef enum logic [2:0] {K_NOP, K_WR, K_SET, K_ERASE, K_START} cmd_kind_t;

  typedef struct packed {
    logic [OP_W-1:0]    op;
    logic [RADDR_W-1:0] raddr;
    logic [EADDR_W-1:0] eaddr;
    logic [DATA_W-1:0]  data;
  } cmd_fields_t;

  function automatic cmd_fields_t split_word(input logic [USED_W-1:0] w);
    cmd_fields_t f;
    f.data  = w[DATA_W-1:0];
    f.eaddr = w[EA_LSB +: EADDR_W];
    f.raddr = w[RA_LSB +: RADDR_W];
    f.op    = w[OP_LSB +: OP_W];
    return f;
  endfunction

  function automatic cmd_kind_t classify(input logic [OP_W-1:0] op);
    case (op)
      4'h1:                      return K_WR;
      4'h2:                      return K_SET;
      4'h4:                      return K_ERASE;
      4'h8, 4'hA, 4'hC, 4'hE:    return K_START;
      default:                   return K_NOP;
    endcase
  endfunction

  function automatic logic op_reload(input logic [OP_W-1:0] op);
    return op[1];
  endfunction

  function automatic logic op_trace(input logic [OP_W-1:0] op);
    return ~op[2];
  endfunction
endpackage

// File: rtl/tcr_init_det.sv
module tcr_init_det #(
  parameter int INIT_LOW = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic act,
  input  logic line,
  output logic begin_w
);
  localparam int CNT_W = $clog2(INIT_LOW + 1);

  logic [CNT_W-1:0] low_cnt;
  logic             prev_line;
  logic             armed;

  assign armed   = (low_cnt == CNT_W'(INIT_LOW));
  assign begin_w = act & line & ~prev_line & armed;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      low_cnt   <= '0;
      prev_line <= 1'b1;
    end else if (act) begin
      prev_line <= line;
      if (line)
        low_cnt <= '0;
      else if (!armed)
        low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tcr_shifter.sv
module tcr_shifter
  import tcr_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic              act,
  input  logic              line,
  input  logic              sdata,
  input  logic              begin_w,
  output logic              word_done,
  output logic [USED_W-1:0] word,
  output logic              halted
);
  localparam int BC_W = $clog2(WORD_W);
  localparam logic [BC_W-1:0] LAST = BC_W'(WORD_W - 1);

  rx_state_t         state;
  logic [WORD_W-1:0] sr;
  logic [WORD_W-1:0] nxt;
  logic [BC_W-1:0]   bcnt;
  logic              is_start;

  assign nxt       = {sdata, sr[WORD_W-1:1]};
  assign word      = nxt[USED_W-1:0];
  assign is_start  = (classify(nxt[OP_LSB +: OP_W]) == K_START);
  assign word_done = act & line & (state == ST_SHIFT) & (bcnt == LAST);
  assign halted    = (state == ST_HALT);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state <= ST_IDLE;
      sr    <= '0;
      bcnt  <= '0;
    end else if (act) begin
      if (!line) begin
        state <= ST_IDLE;
        bcnt  <= '0;
      end else begin
        case (state)
          ST_IDLE: if (begin_w) begin
            sr    <= nxt;
            bcnt  <= BC_W'(1);
            state <= ST_SHIFT;
          end
          ST_SHIFT: begin
            sr <= nxt;
            if (bcnt == LAST) begin
              bcnt <= '0;
              if (is_start) state <= ST_HALT;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tcr_decode.sv
module tcr_decode
  import tcr_pkg::*;
(
  input  logic               clk,
  input  logic               arst_n,
  input  logic               word_done,
  input  logic [USED_W-1:0]  word,
  output logic               cmd_wr,
  output logic               cmd_set,
  output logic               cmd_erase,
  output logic               cmd_nop,
  output logic               cmd_start,
  output logic               start_reload,
  output logic               start_trace,
  output logic [DATA_W-1:0]  fld_data,
  output logic [EADDR_W-1:0] fld_eaddr,
  output logic [RADDR_W-1:0] fld_raddr
);
  cmd_fields_t f;
  cmd_kind_t   kind;

  assign f    = split_word(word);
  assign kind = classify(f.op);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cmd_wr       <= 1'b0;
      cmd_set      <= 1'b0;
      cmd_erase    <= 1'b0;
      cmd_nop      <= 1'b0;
      cmd_start    <= 1'b0;
      start_reload <= 1'b0;
      start_trace  <= 1'b0;
      fld_data     <= '0;
      fld_eaddr    <= '0;
      fld_raddr    <= '0;
    end else begin
      cmd_wr    <= word_done & (kind == K_WR);
      cmd_set   <= word_done & (kind == K_SET);
      cmd_erase <= word_done & (kind == K_ERASE);
      cmd_nop   <= word_done & (kind == K_NOP);
      cmd_start <= word_done & (kind == K_START);
      if (word_done) begin
        start_reload <= op_reload(f.op);
        start_trace  <= op_trace(f.op);
        fld_data     <= f.data;
        fld_eaddr    <= f.eaddr;
        fld_raddr    <= f.raddr;
      end
    end
  end
endmodule

// File: rtl/test_cmd_rx.sv
module test_cmd_rx
  import tcr_pkg::*;
#(
  parameter int INIT_LOW = 16
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               test_en,
  input  logic               cs_a,
  input  logic               cs_b,
  input  logic               init_line,
  input  logic               sdata,
  output logic               cmd_wr,
  output logic               cmd_set,
  output logic               cmd_erase,
  output logic               cmd_nop,
  output logic               cmd_start,
  output logic               start_reload,
  output logic               start_trace,
  output logic [DATA_W-1:0]  fld_data,
  output logic [EADDR_W-1:0] fld_eaddr,
  output logic [RADDR_W-1:0] fld_raddr,
  output logic               coef_clr
);
  logic              act;
  logic              begin_w;
  logic              word_done;
  logic              halted;
  logic [USED_W-1:0] word;

  assign act = test_en & cs_a & cs_b;

  tcr_init_det #(.INIT_LOW(INIT_LOW)) u_init (
    .clk(clk), .arst_n(arst_n), .act(act), .line(init_line), .begin_w(begin_w)
  );

  tcr_shifter u_shift (
    .clk(clk), .arst_n(arst_n), .act(act), .line(init_line), .sdata(sdata),
    .begin_w(begin_w), .word_done(word_done), .word(word), .halted(halted)
  );

  tcr_decode u_dec (
    .clk(clk), .arst_n(arst_n), .word_done(word_done), .word(word),
    .cmd_wr(cmd_wr), .cmd_set(cmd_set), .cmd_erase(cmd_erase), .cmd_nop(cmd_nop),
    .cmd_start(cmd_start), .start_reload(start_reload), .start_trace(start_trace),
    .fld_data(fld_data), .fld_eaddr(fld_eaddr), .fld_raddr(fld_raddr)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) coef_clr <= 1'b0;
    else         coef_clr <= act & ~init_line;
  end
endmodule

// File: rtl/tcr_checker.sv
module tcr_checker (
  input logic        clk,
  input logic        arst_n,
  input logic        act,
  input logic        line,
  input logic        halted,
  input logic        wr,
  input logic        set,
  input logic        erase,
  input logic        nop,
  input logic        start,
  input logic        reload,
  input logic        trace,
  input logic [15:0] data,
  input logic [6:0]  eaddr,
  input logic [2:0]  raddr,
  input logic        clr
);
  logic strb_any;
  assign strb_any = wr | set | erase | nop | start;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({wr, set, erase, nop, start})); // R4

  AST_DEAD_LINK_QUIET: assert property (@(posedge clk) disable iff (!arst_n)
    !act |=> !strb_any && !clr); // R1

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    strb_any |=> !strb_any); // R9

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!arst_n)
    !strb_any |-> $stable({data, eaddr, raddr, reload, trace})); // R9

  AST_PARKED_SILENT: assert property (@(posedge clk) disable iff (!arst_n)
    halted |=> !strb_any); // R7

  AST_CLEAR_FOLLOWS: assert property (@(posedge clk) disable iff (!arst_n)
    act && !line |=> clr); // R8
endmodule

bind test_cmd_rx tcr_checker u_chk (
  .clk(clk), .arst_n(arst_n), .act(act), .line(init_line), .halted(halted),
  .wr(cmd_wr), .set(cmd_set), .erase(cmd_erase), .nop(cmd_nop), .start(cmd_start),
  .reload(start_reload), .trace(start_trace), .data(fld_data), .eaddr(fld_eaddr),
  .raddr(fld_raddr), .clr(coef_clr)
);

// File: tb/test_cmd_rx_test.sv
module test_cmd_rx_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic test_en = 1'b1, cs_a = 1'b1, cs_b = 1'b1, init_line = 1'b1, sdata = 1'b0;
  logic cmd_wr, cmd_set, cmd_erase, cmd_nop, cmd_start, start_reload, start_trace, coef_clr;
  logic [15:0] fld_data;
  logic [6:0]  fld_eaddr;
  logic [2:0]  fld_raddr;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  test_cmd_rx uut (
    .clk(clk), .arst_n(arst_n), .test_en(test_en), .cs_a(cs_a), .cs_b(cs_b),
    .init_line(init_line), .sdata(sdata), .cmd_wr(cmd_wr), .cmd_set(cmd_set),
    .cmd_erase(cmd_erase), .cmd_nop(cmd_nop), .cmd_start(cmd_start),
    .start_reload(start_reload), .start_trace(start_trace), .fld_data(fld_data),
    .fld_eaddr(fld_eaddr), .fld_raddr(fld_raddr), .coef_clr(coef_clr)
  );

  // expected strobe vector order: {wr, set, erase, nop, start}
  typedef struct packed {
    logic [1:0]  unused;
    logic [3:0]  op;
    logic [2:0]  ra;
    logic [6:0]  ea;
    logic [15:0] d;
    logic [4:0]  exp;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{2'b00, 4'h1, 3'd5, 7'h11, 16'hA5C3, 5'b10000},
    '{2'b11, 4'h2, 3'd0, 7'h7F, 16'h0000, 5'b01000},
    '{2'b00, 4'h4, 3'd7, 7'h00, 16'hFFFF, 5'b00100},
    '{2'b00, 4'h0, 3'd2, 7'h3C, 16'h1234, 5'b00010},
    '{2'b01, 4'h3, 3'd1, 7'h01, 16'h0F0F, 5'b00010},
    '{2'b00, 4'h5, 3'd6, 7'h40, 16'h8000, 5'b00010},
    '{2'b10, 4'h9, 3'd3, 7'h2A, 16'h0001, 5'b00010},
    '{2'b00, 4'hF, 3'd4, 7'h55, 16'h7FFE, 5'b00010},
    '{2'b10, 4'h1, 3'd0, 7'h00, 16'h8001, 5'b10000}
  };

  function automatic logic [31:0] mk(input logic [1:0] u, input logic [3:0] op,
                                     input logic [2:0] ra, input logic [6:0] ea,
                                     input logic [15:0] d);
    return {u, op, ra, ea, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [4:0] strobes();
    return {cmd_wr, cmd_set, cmd_erase, cmd_nop, cmd_start};
  endfunction

  task automatic init_seq(input int n);
    init_line = 1'b0;
    repeat (n) @(negedge clk);
    init_line = 1'b1;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 0; i < 32; i++) begin
      sdata = w[i];
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset strobes", 32'(strobes()), 32'h0);
    chk("R9 reset fields", {6'h0, fld_data, fld_eaddr, fld_raddr}, 32'h0);
    chk("R8 reset clr", 32'(coef_clr), 32'h0);
    arst_n = 1'b1;
    @(negedge clk);

    // R1: test mode off, a full init and word are ignored
    test_en = 1'b0;
    init_seq(20);
    chk("R1 clr while disabled", 32'(coef_clr), 32'h0);
    send_word(mk(2'b00, 4'h1, 3'd1, 7'h01, 16'h1111));
    chk("R1 no strobe while disabled", 32'(strobes()), 32'h0);
    test_en = 1'b1;

    // R8: clear request follows a live low framing line
    @(negedge clk);
    init_line = 1'b0;
    @(negedge clk);
    chk("R8 clr raised", 32'(coef_clr), 32'h1);
    test_en = 1'b0;
    @(negedge clk);
    chk("R8 clr dropped when not live", 32'(coef_clr), 32'h0);
    test_en = 1'b1;
    init_line = 1'b1;
    @(negedge clk);

    // R1 + R3: word interrupted by deselection with garbage on the pins
    init_seq(16);
    begin
      logic [31:0] w;
      w = mk(2'b00, 4'h1, 3'd6, 7'h5A, 16'hBEEF);
      for (int i = 0; i < 32; i++) begin
        if (i == 10) begin
          cs_b = 1'b0;
          for (int g = 0; g < 5; g++) begin
            sdata = ~sdata;
            init_line = 1'b0;
            @(negedge clk);
          end
          chk("R1 clr low while deselected", 32'(coef_clr), 32'h0);
          cs_b = 1'b1;
          init_line = 1'b1;
        end
        sdata = w[i];
        @(negedge clk);
      end
    end
    chk("R1 resumed word strobe", 32'(strobes()), 32'h10);
    chk("R3 resumed data", 32'(fld_data), 32'hBEEF);
    chk("R3 resumed eaddr", 32'(fld_eaddr), 32'h5A);
    chk("R3 resumed raddr", 32'(fld_raddr), 32'h6);

    // R10: table of words streamed back to back (R3, R4, R5)
    init_line = 1'b0;
    @(negedge clk);
    init_seq(16);
    for (int k = 0; k < 9; k++) begin
      send_word(mk(TBL[k].unused, TBL[k].op, TBL[k].ra, TBL[k].ea, TBL[k].d));
      chk("R4 R5 R10 strobe vector", 32'(strobes()), 32'(TBL[k].exp));
      chk("R3 data field", 32'(fld_data), 32'(TBL[k].d));
      chk("R3 eaddr field", 32'(fld_eaddr), 32'(TBL[k].ea));
      chk("R3 raddr field", 32'(fld_raddr), 32'(TBL[k].ra));
    end
    // R9: single-cycle strobe, fields held
    @(negedge clk);
    chk("R9 strobe dropped", 32'(strobes()), 32'h0);
    chk("R9 data held", 32'(fld_data), 32'h8001);

    // R2: fifteen low cycles do not initialize
    init_seq(15);
    send_word(mk(2'b00, 4'h1, 3'd2, 7'h02, 16'h2222));
    chk("R2 short init ignored", 32'(strobes()), 32'h0);
    chk("R2 fields untouched", 32'(fld_data), 32'h8001);

    // R11: early framing drop discards the word and needs a new init
    init_seq(16);
    for (int i = 0; i < 10; i++) begin
      sdata = i[0];
      @(negedge clk);
    end
    init_line = 1'b0;
    @(negedge clk);
    init_line = 1'b1;
    send_word(mk(2'b00, 4'h2, 3'd1, 7'h33, 16'h3333));
    chk("R11 aborted word silent", 32'(strobes()), 32'h0);
    init_seq(16);
    send_word(mk(2'b00, 4'h2, 3'd1, 7'h33, 16'h3333));
    chk("R11 recovery after init", 32'(strobes()), 32'h08);

    // R6 + R7: start variants, each parks the receiver
    begin
      logic [3:0] sop [4];
      logic       xrl [4];
      logic       xtr [4];
      sop = '{4'h8, 4'hA, 4'hC, 4'hE};
      xrl = '{1'b0, 1'b1, 1'b0, 1'b1};
      xtr = '{1'b1, 1'b1, 1'b0, 1'b0};
      for (int s = 0; s < 4; s++) begin
        init_seq(16);
        send_word(mk(2'b00, sop[s], 3'd0, 7'h00, 16'h0000));
        chk("R6 start strobe", 32'(strobes()), 32'h01);
        chk("R6 reload qualifier", 32'(start_reload), 32'(xrl[s]));
        chk("R6 trace qualifier", 32'(start_trace), 32'(xtr[s]));
        send_word(mk(2'b00, 4'h1, 3'd3, 7'h03, 16'h4444));
        chk("R7 parked after start", 32'(strobes()), 32'h0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule